// File: doc/BRIEF.md
# Read-After-Write Bypass for Synchronous-Read Memory

This block sits between a requester and a memory whose read port is registered and which, when read and written at one address in the same cycle, returns the contents held before that write. The wrapper hands the read address and the optional write request to the memory without altering them. It watches for a read and a write to the same location in one cycle. In the following cycle it puts the freshly written word on its output in place of the memory's older value.

The wrapper holds no storage array. It keeps one hit flag and one copy of the write data. Its output has the same one-cycle latency as the memory behind it. A clock enable freezes the wrapper together with the memory, and reset clears the hit flag. Addresses are only compared for equality.

Top module: `raw_bypass`

## Requirements
- R1: The write request (`wr_valid`, `wr_addr`, `wr_data`) appears unchanged and in the same cycle on `mem_wr_valid`, `mem_wr_addr`, `mem_wr_data`.
- R2: `rd_addr` appears unchanged and in the same cycle on `mem_rd_addr`.
- R3: A same-address read and write presented in a cycle where reset is active does not forward. In the first cycle after that edge, `rd_data` equals `mem_rd_data`.
- R4: If `en` is high, `wr_valid` is high and `wr_addr` equals `rd_addr` at a clock edge, then in the following cycle `rd_data` equals the `wr_data` sampled at that edge.
- R5: If `en` is high and there is no write, or the write targets a different address, at a clock edge, then in the following cycle `rd_data` equals `mem_rd_data`.
- R6: While `en` is low at an edge, the hit flag and the captured write data keep their values, so `rd_data` keeps the same source it had.
- R7: The read result is valid exactly one cycle after the address, which is the same latency as the inner memory. Back-to-back reads each return their own word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| en | input | 1 | Clock enable shared with the inner memory |
| rd_addr | input | AW | Read address |
| wr_valid | input | 1 | Write request present |
| wr_addr | input | AW | Write address |
| wr_data | input | DW | Write data |
| mem_rd_addr | output | AW | Read address to the inner memory |
| mem_wr_valid | output | 1 | Write request to the inner memory |
| mem_wr_addr | output | AW | Write address to the inner memory |
| mem_wr_data | output | DW | Write data to the inner memory |
| mem_rd_data | input | DW | Registered read data from the inner memory (old value on collision) |
| rd_data | output | DW | Read data with read-after-write semantics |

## Verification
The bench builds the wrapper with AW=3 and DW=8 and puts a read-before-write model of an 8-entry memory behind it. This small size lets the bench sweep every pair of read and write addresses, both with a write present and without one. An expected-value shadow array computes the value seen after each write. Further steps cover reset during a collision and enable-low stretches that follow both a hit and a miss.

// File: rtl/raw_bypass.sv
module raw_bypass #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic [AW-1:0] rd_addr,
  input  logic          wr_valid,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  output logic [AW-1:0] mem_rd_addr,
  output logic          mem_wr_valid,
  output logic [AW-1:0] mem_wr_addr,
  output logic [DW-1:0] mem_wr_data,
  input  logic [DW-1:0] mem_rd_data,
  output logic [DW-1:0] rd_data
);
  logic          hit_q;
  logic [DW-1:0] fwd_q;
  logic          hit_now;

  assign mem_rd_addr  = rd_addr;
  assign mem_wr_valid = wr_valid;
  assign mem_wr_addr  = wr_addr;
  assign mem_wr_data  = wr_data;

  assign hit_now = wr_valid && (wr_addr == rd_addr);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= 1'b0;
      fwd_q <= '0;
    end else if (en) begin
      hit_q <= hit_now;
      fwd_q <= wr_data;
    end
  end

  assign rd_data = hit_q ? fwd_q : mem_rd_data;
endmodule

module raw_bypass_chk #(
  parameter int AW = 5,
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          en,
  input logic [AW-1:0] rd_addr,
  input logic          wr_valid,
  input logic [AW-1:0] wr_addr,
  input logic [DW-1:0] wr_data,
  input logic [DW-1:0] mem_rd_data,
  input logic [DW-1:0] rd_data,
  input logic          hit_q,
  input logic [DW-1:0] fwd_q
);
  AST_RESET_NO_FWD: assert property (@(posedge clk) !rst_n |=> rd_data == mem_rd_data); // R3
  AST_HIT_FORWARD: assert property (@(posedge clk) disable iff (!rst_n)
    (en && wr_valid && wr_addr == rd_addr) |=> rd_data == $past(wr_data)); // R4
  AST_MISS_MEMORY: assert property (@(posedge clk) disable iff (!rst_n)
    (en && !(wr_valid && wr_addr == rd_addr)) |=> rd_data == mem_rd_data); // R5
  AST_HOLD_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(hit_q)); // R6
  AST_HOLD_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> $stable(fwd_q)); // R6
endmodule

bind raw_bypass raw_bypass_chk #(.AW(AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .en(en), .rd_addr(rd_addr), .wr_valid(wr_valid),
  .wr_addr(wr_addr), .wr_data(wr_data), .mem_rd_data(mem_rd_data),
  .rd_data(rd_data), .hit_q(hit_q), .fwd_q(fwd_q)
);

// File: tb/raw_bypass_tb.sv
module raw_bypass_tb;
  localparam int AW = 3;
  localparam int DW = 8;
  localparam int DEPTH = 1 << AW;
  localparam time CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic en = 1'b1;
  logic [AW-1:0] rd_addr = '0;
  logic wr_valid = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic [AW-1:0] mem_rd_addr;
  logic mem_wr_valid;
  logic [AW-1:0] mem_wr_addr;
  logic [DW-1:0] mem_wr_data;
  logic [DW-1:0] mem_rd_data = '0;
  logic [DW-1:0] rd_data;

  logic [DW-1:0] mem [DEPTH];
  logic [DW-1:0] shadow [DEPTH];
  logic [DW-1:0] exp_q = '0;
  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  raw_bypass #(.AW(AW), .DW(DW)) u_dut (
    .clk(clk), .rst_n(rst_n), .en(en), .rd_addr(rd_addr), .wr_valid(wr_valid),
    .wr_addr(wr_addr), .wr_data(wr_data), .mem_rd_addr(mem_rd_addr),
    .mem_wr_valid(mem_wr_valid), .mem_wr_addr(mem_wr_addr),
    .mem_wr_data(mem_wr_data), .mem_rd_data(mem_rd_data), .rd_data(rd_data)
  );

  always_ff @(posedge clk) begin
    if (en) begin
      mem_rd_data <= mem[mem_rd_addr];
      if (mem_wr_valid) mem[mem_wr_addr] <= mem_wr_data;
    end
  end

  always @(posedge clk) begin
    cycles <= cycles + 1;
    if (cycles > 100000) begin
      fails = fails + 1;
      checks = checks + 1;
      $display("FAIL watchdog: actual %0d cycles expected under 100000", cycles);
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] expv);
    checks = checks + 1;
    if (act !== expv) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0h expected %0h", req, act, expv);
    end
  endtask

  task automatic step(input logic [AW-1:0] ra, input logic wv, input logic [AW-1:0] wa,
                      input logic [DW-1:0] wd, input logic e, input string req);
    rd_addr = ra; wr_valid = wv; wr_addr = wa; wr_data = wd; en = e;
    #1;
    check("R1 wr_valid", 32'(mem_wr_valid), 32'(wv));
    check("R1 wr_addr", 32'(mem_wr_addr), 32'(wa));
    check("R1 wr_data", 32'(mem_wr_data), 32'(wd));
    check("R2 rd_addr", 32'(mem_rd_addr), 32'(ra));
    if (e) begin
      exp_q = (wv && wa == ra) ? wd : shadow[ra];
      if (wv) shadow[wa] = wd;
    end
    @(posedge clk);
    @(negedge clk);
    check(req, 32'(rd_data), 32'(exp_q));
  endtask

  initial begin
    for (int i = 0; i < DEPTH; i++) begin
      mem[i] = DW'(i * 17 + 3);
      shadow[i] = DW'(i * 17 + 3);
    end
    @(negedge clk);
    @(negedge clk);
    // R3: collision at address 2 while reset is active, released at next negedge
    rd_addr = 3'd2; wr_valid = 1'b1; wr_addr = 3'd2; wr_data = 8'hA5; en = 1'b1;
    @(posedge clk);
    shadow[2] = 8'hA5;
    @(negedge clk);
    rst_n = 1'b1;
    check("R3 reset blocks forwarding", 32'(rd_data), 32'(2 * 17 + 3));
    // R4/R5: sweep every read/write address pair
    for (int r = 0; r < DEPTH; r++) begin
      for (int w = 0; w < DEPTH; w++) begin
        step(AW'(r), 1'b1, AW'(w), DW'(r * 8 + w + 64), 1'b1, (r == w) ? "R4 hit" : "R5 miss");
        step(AW'(r), 1'b0, AW'(w), 8'hFF, 1'b1, "R5 plain read");
      end
    end
    // R7: back-to-back reads return their own words
    for (int r = 0; r < DEPTH; r++) step(AW'(DEPTH - 1 - r), 1'b0, '0, '0, 1'b1, "R7 back-to-back");
    // R6: enable low after a hit, then after a miss
    step(3'd5, 1'b1, 3'd5, 8'h3C, 1'b1, "R4 hit before hold");
    step(3'd1, 1'b1, 3'd1, 8'hC3, 1'b0, "R6 hold after hit");
    step(3'd0, 1'b1, 3'd0, 8'h77, 1'b0, "R6 hold after hit 2");
    step(3'd5, 1'b0, 3'd0, 8'h00, 1'b1, "R5 read after hold");
    step(3'd6, 1'b1, 3'd2, 8'h11, 1'b1, "R5 miss before hold");
    step(3'd6, 1'b1, 3'd6, 8'h99, 1'b0, "R6 hold after miss");
    step(3'd6, 1'b0, 3'd0, 8'h00, 1'b1, "R6 disabled write dropped");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule